// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register side of a simple serial port. A processor reaches it through a 32-bit word-indexed register port. Behind that port sit four control words, a FIFO-control word, two status words, a test word, the baud count, baud modulator and one-millisecond words, and a single-character receive holding buffer. There is no FIFO.

Bytes written to the transmit index leave on an 8-bit valid/ready interface. Bit serialization happens elsewhere. Received bytes and line-break events arrive on a byte-input interface. A ready output on that interface stays low while the holding buffer is occupied. A read of the receive index is a destructive handshake that releases the buffer.

One level-sensitive interrupt output is built from status bits that are gated by enable bits held in two different control words. The interrupt is registered, so it follows the state one clock later.

Top module: `sreg_top`

## Requirements
- R1: After reset the port reads back these values:
  - status 1 = 0x6040 (transmit-ready bit 13, RTS-state bit 14, receive-idle bit 6)
  - status 2 = 0x4028 (TX-FIFO-empty bit 14, transmit-complete bit 3, DCD-in bit 5)
  - test word (index 0x2D) = 0x0060 (RX-empty bit 5, TX-empty bit 6)
  - control 1 = 0, control 2 = 0x0001, control 3 = 0x0700, modulator = 0, baud count = 4
  - receive index (0x00) = 0x4000 (error bit 14 only)
  - irq = 0
- R2: The register indices are: receive data 0x00, transmit data 0x10, control 1 to 4 at 0x20 to 0x23, FIFO control 0x24, status 1 and 2 at 0x25 and 0x26, baud incremental 0x29, modulator 0x2A, baud count 0x2B, one-millisecond 0x2C, test 0x2D.
  - The control, FIFO-control, baud and one-millisecond words keep only the low 16 bits of a write.
  - A write to index 0x29 updates the baud count, and a read of 0x29 returns 0.
  - Writes to the test word are ignored.
  - Reads of unmapped indices return 0.
- R3: A write to control 2 with bit 0 at 0 restores the R1 image in both status words, the test word, control 1, control 3, the modulator, the baud count and the receive buffer. Control 2 then holds the written low 16 bits with bit 0 forced to 1.
- R4: A read of index 0x00 (busRe high) while test bit 5 is clear behaves as follows:
  - it returns the buffered word with bit 15 (char-ready) set;
  - it clears status 1 bit 9 and status 2 bit 0;
  - it sets test bit 5.
  A read while test bit 5 is set returns the buffer without bit 15 and changes nothing.
- R5: An accepted character does the following:
  - sets status 1 bit 9 (receive-ready) and status 2 bit 0 (receive-data-ready);
  - clears test bit 5;
  - stores the byte in buffer bits 7:0.
  A line-break event stores the word 0x5400 (break bit 10, frame-error bit 12, error bit 14) and also sets status 2 bit 2 (break-detected).
- R6: rxAccept equals the inverse of status 1 bit 9. A character or break presented while rxAccept is low is dropped and leaves the buffer unchanged.
- R7: A write to index 0x10 is taken only when control 2 bit 2 (TX-enable) is set and no byte is pending. Taking it raises txValid with the byte and clears status 1 bit 13 and status 2 bit 3. When the byte is consumed (txValid and txReady at a clock edge), txValid drops and both bits are set again.
- R8: Writing 1s to status 1 clears only bits within mask 0x9DB0. Writing 1s to status 2 clears only bits within mask 0xBDD6, which includes break-detected bit 2. Every other status bit is unaffected.
- R9: The irq has a receive/transmit term that is high when status 1 and control 1 share a set bit at position 13 or 9.
- R10: The irq has a status 2 term that is high for any of these:
  - status 2 bit 14 is set and control 1 bit 6 is set;
  - status 2 bit 3 is set and control 4 bit 3 is set;
  - status 2 bit 0 is set and control 4 bit 0 is set.
- R11: irq is a register. It reflects the state of the previous cycle, so a change made at one clock edge shows on irq after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Register word index |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read strobe that qualifies side-effecting reads |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| txByte | output | 8 | Byte to transmit |
| txValid | output | 1 | A transmit byte is pending |
| txReady | input | 1 | The consumer takes the pending byte |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | rxData is presented |
| rxBreak | input | 1 | A line-break event is presented |
| rxAccept | output | 1 | The holding buffer is free |
| irq | output | 1 | Registered level interrupt |

## Verification
The receive path is driven with three patterns: an ordinary byte, a second byte offered while the buffer is full, and a break event. Together they separate a correct single-entry handshake from an overwrite, and separate break flagging from plain data.

Transmit writes are made both with TX-enable clear and with it set, and the consumer stalls before it accepts. This shows that the byte is gated, that it holds while stalled, and that the status flags drop and then return.

Each interrupt enable is turned on alone against a status bit that is set and against one that is clear. This shows which enable reaches which source, and that irq lags the state by one clock. A soft reset is issued after the registers have been disturbed, and its restored image is compared with the hardware reset image.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int REG_W = 16;

  localparam logic [5:0] IDX_RXD  = 6'h00;
  localparam logic [5:0] IDX_TXD  = 6'h10;
  localparam logic [5:0] IDX_CR1  = 6'h20;
  localparam logic [5:0] IDX_CR2  = 6'h21;
  localparam logic [5:0] IDX_CR3  = 6'h22;
  localparam logic [5:0] IDX_CR4  = 6'h23;
  localparam logic [5:0] IDX_FIFO = 6'h24;
  localparam logic [5:0] IDX_SR1  = 6'h25;
  localparam logic [5:0] IDX_SR2  = 6'h26;
  localparam logic [5:0] IDX_BINC = 6'h29;
  localparam logic [5:0] IDX_BMOD = 6'h2A;
  localparam logic [5:0] IDX_BCNT = 6'h2B;
  localparam logic [5:0] IDX_MS   = 6'h2C;
  localparam logic [5:0] IDX_TST  = 6'h2D;

  // bit positions
  localparam int B_CHRDY = 15;
  localparam int B_TRDY  = 13;
  localparam int B_RRDY  = 9;
  localparam int B_TXFE  = 14;
  localparam int B_TXDC  = 3;
  localparam int B_BRCD  = 2;
  localparam int B_RDR   = 0;
  localparam int B_TXEIE = 6;
  localparam int B_SRSTN = 0;
  localparam int B_TXEN  = 2;
  localparam int B_RXMT  = 5;

  localparam logic [REG_W-1:0] SR1_INIT  = 16'h6040;
  localparam logic [REG_W-1:0] SR2_INIT  = 16'h4028;
  localparam logic [REG_W-1:0] TST_INIT  = 16'h0060;
  localparam logic [REG_W-1:0] CR2_INIT  = 16'h0001;
  localparam logic [REG_W-1:0] CR3_INIT  = 16'h0700;
  localparam logic [REG_W-1:0] BCNT_INIT = 16'h0004;
  localparam logic [REG_W-1:0] RXB_INIT  = 16'h4000;
  localparam logic [REG_W-1:0] BRK_WORD  = 16'h5400;
  localparam logic [REG_W-1:0] SR1_W1C   = 16'h9DB0;
  localparam logic [REG_W-1:0] SR2_W1C   = 16'hBDD6;
  localparam logic [REG_W-1:0] SR1_IRQ   = 16'h2200;
  localparam logic [REG_W-1:0] CR4_IRQ   = 16'h0009;

  typedef struct packed {
    logic softRst;
    logic wrCr1;
    logic wrCr2;
    logic wrCr3;
    logic wrCr4;
    logic wrFifo;
    logic wrSr1;
    logic wrSr2;
    logic wrBaudCnt;
    logic wrBaudMod;
    logic wrOneMs;
    logic txLoad;
    logic txDone;
    logic rxLoad;
    logic rxBrk;
    logic rxRead;
  } strobe_t;

  typedef struct packed {
    logic [REG_W-1:0] sr1;
    logic [REG_W-1:0] sr2;
    logic [REG_W-1:0] tst;
    logic [REG_W-1:0] cr1;
    logic [REG_W-1:0] cr2;
    logic [REG_W-1:0] cr4;
    logic             txBusy;
  } stat_t;
endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              wrLsb,
  input  logic              rxValid,
  input  logic              rxBreak,
  input  logic              txReady,
  input  stat_t             stat,
  output strobe_t           stb
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [5:0] idx);
    return a == ADDR_W'(idx);
  endfunction

  logic rxFull;
  assign rxFull = stat.sr1[B_RRDY];

  always_comb begin
    stb           = '0;
    stb.wrCr1     = busWe && hit(busAddr, IDX_CR1);
    stb.wrCr2     = busWe && hit(busAddr, IDX_CR2);
    stb.wrCr3     = busWe && hit(busAddr, IDX_CR3);
    stb.wrCr4     = busWe && hit(busAddr, IDX_CR4);
    stb.wrFifo    = busWe && hit(busAddr, IDX_FIFO);
    stb.wrSr1     = busWe && hit(busAddr, IDX_SR1);
    stb.wrSr2     = busWe && hit(busAddr, IDX_SR2);
    stb.wrBaudCnt = busWe && (hit(busAddr, IDX_BINC) || hit(busAddr, IDX_BCNT));
    stb.wrBaudMod = busWe && hit(busAddr, IDX_BMOD);
    stb.wrOneMs   = busWe && hit(busAddr, IDX_MS);
    stb.softRst   = stb.wrCr2 && !wrLsb;
    stb.txLoad    = busWe && hit(busAddr, IDX_TXD) && stat.cr2[B_TXEN] && !stat.txBusy;
    stb.txDone    = stat.txBusy && txReady;
    stb.rxLoad    = (rxValid || rxBreak) && !rxFull;
    stb.rxBrk     = rxBreak;
    stb.rxRead    = busRe && hit(busAddr, IDX_RXD) && !stat.tst[B_RXMT];
  end
endmodule

// File: rtl/sreg_dp.sv
module sreg_dp
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] rxData,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq,
  output stat_t             stat
);
  logic [REG_W-1:0] cr1Q, cr2Q, cr3Q, cr4Q, fifoQ, sr1Q, sr2Q, tstQ;
  logic [REG_W-1:0] bmodQ, bcntQ, msQ, rxBufQ;
  logic [REG_W-1:0] sr1N, sr2N, tstN, rxBufN, wLow;
  logic             busyQ, busyN;
  logic [BYTE_W-1:0] txQ;

  assign wLow = busWdata[REG_W-1:0];

  always_comb begin
    sr1N   = sr1Q;
    sr2N   = sr2Q;
    tstN   = tstQ;
    rxBufN = rxBufQ;
    busyN  = busyQ;
    if (stb.wrSr1) sr1N = sr1N & ~(wLow & SR1_W1C);
    if (stb.wrSr2) sr2N = sr2N & ~(wLow & SR2_W1C);
    if (stb.txLoad) begin
      busyN = 1'b1;
      sr1N[B_TRDY] = 1'b0;
      sr2N[B_TXDC] = 1'b0;
    end
    if (stb.txDone) begin
      busyN = 1'b0;
      sr1N[B_TRDY] = 1'b1;
      sr2N[B_TXDC] = 1'b1;
    end
    if (stb.rxLoad) begin
      sr1N[B_RRDY] = 1'b1;
      sr2N[B_RDR]  = 1'b1;
      tstN[B_RXMT] = 1'b0;
      if (stb.rxBrk) begin
        rxBufN = BRK_WORD;
        sr2N[B_BRCD] = 1'b1;
      end else begin
        rxBufN = REG_W'(rxData);
      end
    end
    if (stb.rxRead) begin
      sr1N[B_RRDY] = 1'b0;
      sr2N[B_RDR]  = 1'b0;
      tstN[B_RXMT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr1Q <= '0; cr2Q <= CR2_INIT; cr3Q <= CR3_INIT; cr4Q <= '0;
      fifoQ <= '0; sr1Q <= SR1_INIT; sr2Q <= SR2_INIT; tstQ <= TST_INIT;
      bmodQ <= '0; bcntQ <= BCNT_INIT; msQ <= '0; rxBufQ <= RXB_INIT;
      busyQ <= 1'b0; txQ <= '0;
    end else if (stb.softRst) begin
      cr1Q <= '0; cr2Q <= wLow | CR2_INIT; cr3Q <= CR3_INIT;
      sr1Q <= SR1_INIT; sr2Q <= SR2_INIT; tstQ <= TST_INIT;
      bmodQ <= '0; bcntQ <= BCNT_INIT; rxBufQ <= RXB_INIT;
      busyQ <= 1'b0;
    end else begin
      sr1Q <= sr1N; sr2Q <= sr2N; tstQ <= tstN;
      rxBufQ <= rxBufN; busyQ <= busyN;
      if (stb.txLoad)    txQ   <= busWdata[BYTE_W-1:0];
      if (stb.wrCr1)     cr1Q  <= wLow;
      if (stb.wrCr2)     cr2Q  <= wLow;
      if (stb.wrCr3)     cr3Q  <= wLow;
      if (stb.wrCr4)     cr4Q  <= wLow;
      if (stb.wrFifo)    fifoQ <= wLow;
      if (stb.wrBaudCnt) bcntQ <= wLow;
      if (stb.wrBaudMod) bmodQ <= wLow;
      if (stb.wrOneMs)   msQ   <= wLow;
    end
  end

  logic [REG_W-1:0] sr2Mask;
  logic             irqD;
  always_comb begin
    sr2Mask = cr4Q & CR4_IRQ;
    sr2Mask[B_TXFE] = cr1Q[B_TXEIE];
    irqD = |(sr1Q & cr1Q & SR1_IRQ) || |(sr2Q & sr2Mask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= irqD;
  end

  logic [REG_W-1:0] rdLow;
  always_comb begin
    rdLow = '0;
    case (busAddr)
      ADDR_W'(IDX_RXD):  rdLow = tstQ[B_RXMT] ? rxBufQ : (rxBufQ | (REG_W'(1) << B_CHRDY));
      ADDR_W'(IDX_CR1):  rdLow = cr1Q;
      ADDR_W'(IDX_CR2):  rdLow = cr2Q;
      ADDR_W'(IDX_CR3):  rdLow = cr3Q;
      ADDR_W'(IDX_CR4):  rdLow = cr4Q;
      ADDR_W'(IDX_FIFO): rdLow = fifoQ;
      ADDR_W'(IDX_SR1):  rdLow = sr1Q;
      ADDR_W'(IDX_SR2):  rdLow = sr2Q;
      ADDR_W'(IDX_BMOD): rdLow = bmodQ;
      ADDR_W'(IDX_BCNT): rdLow = bcntQ;
      ADDR_W'(IDX_MS):   rdLow = msQ;
      ADDR_W'(IDX_TST):  rdLow = tstQ;
      default:           rdLow = '0;
    endcase
  end
  assign busRdata = DATA_W'(rdLow);
  assign txByte   = txQ;

  assign stat.sr1    = sr1Q;
  assign stat.sr2    = sr2Q;
  assign stat.tst    = tstQ;
  assign stat.cr1    = cr1Q;
  assign stat.cr2    = cr2Q;
  assign stat.cr4    = cr4Q;
  assign stat.txBusy = busyQ;
endmodule

// File: rtl/sreg_top.sv
module sreg_top
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  input  logic              txReady,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              rxBreak,
  output logic              rxAccept,
  output logic              irq
);
  strobe_t stb;
  stat_t   dpStat;

  sreg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .wrLsb(busWdata[0]),
    .rxValid(rxValid), .rxBreak(rxBreak), .txReady(txReady),
    .stat(dpStat), .stb(stb)
  );

  sreg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busWdata(busWdata),
    .rxData(rxData), .busRdata(busRdata), .txByte(txByte), .irq(irq),
    .stat(dpStat)
  );

  assign txValid  = dpStat.txBusy;
  assign rxAccept = !dpStat.sr1[B_RRDY];
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [BYTE_W-1:0] txByte,
  input logic              txValid,
  input logic              txReady,
  input logic              rxValid,
  input logic              rxBreak,
  input logic              rxAccept,
  input logic              irq,
  input stat_t             dpStat
);
  logic sRst;
  assign sRst = busWe && busAddr == ADDR_W'(IDX_CR2) && !busWdata[0];

  logic irqSrc;
  assign irqSrc = |(dpStat.sr1 & dpStat.cr1 & SR1_IRQ)
               || (dpStat.sr2[B_TXFE] && dpStat.cr1[B_TXEIE])
               || |(dpStat.sr2 & dpStat.cr4 & CR4_IRQ);

  // R6
  a_r6_accept_when_free: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.sr1[B_RRDY] |-> !rxAccept);

  // R5
  a_r5_rx_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    (rxAccept && (rxValid || rxBreak) && !sRst) |=> (dpStat.sr1[B_RRDY] && !dpStat.tst[B_RXMT]));

  // R4
  a_r4_read_has_chrdy: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(IDX_RXD) && !dpStat.tst[B_RXMT]) |-> busRdata[B_CHRDY]);

  a_r4_read_releases: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(IDX_RXD) && !dpStat.tst[B_RXMT] && !sRst)
      |=> (!dpStat.sr1[B_RRDY] && dpStat.tst[B_RXMT]));

  // R7
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !sRst) |=> (txValid && $stable(txByte)));

  a_r7_trdy_low_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !dpStat.sr1[B_TRDY]);

  // R3
  a_r3_srst_bit_kept: assert property (@(posedge clk) disable iff (!rstN)
    sRst |=> (dpStat.cr2[0] && dpStat.sr1 == SR1_INIT && dpStat.tst == TST_INIT));

  // R9 R10 R11
  a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(irqSrc)));
endmodule

bind sreg_top sreg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .busRdata(busRdata), .txByte(txByte), .txValid(txValid),
  .txReady(txReady), .rxValid(rxValid), .rxBreak(rxBreak), .rxAccept(rxAccept),
  .irq(irq), .dpStat(dpStat)
);

// File: tb/sreg_top_tb_top.sv
module sreg_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  txByte;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0, rxBreak = 1'b0;
  logic        rxAccept, irq;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sreg_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .txByte(txByte), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .rxBreak(rxBreak),
    .rxAccept(rxAccept), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic rdCheck(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic rxPut(input logic [7:0] b, input bit brk);
    @(negedge clk);
    rxData = b; rxValid = !brk; rxBreak = brk;
    @(negedge clk);
    rxValid = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R6 rxAccept", {31'b0, rxAccept}, 32'h1);
    rdCheck(6'h25, 32'h6040, "R1 status1");
    rdCheck(6'h26, 32'h4028, "R1 status2");
    rdCheck(6'h2D, 32'h0060, "R1 test");
    rdCheck(6'h20, 32'h0000, "R1 ctrl1");
    rdCheck(6'h21, 32'h0001, "R1 ctrl2");
    rdCheck(6'h22, 32'h0700, "R1 ctrl3");
    rdCheck(6'h2A, 32'h0000, "R1 modulator");
    rdCheck(6'h2B, 32'h0004, "R1 baudcnt");
    rdCheck(6'h00, 32'h4000, "R1 rxbuf");
    rdCheck(6'h2D, 32'h0060, "R4 empty read no effect");
  endtask

  task automatic t_regs();
    wr(6'h22, 32'hABCD1234);
    rdCheck(6'h22, 32'h1234, "R2 ctrl3 low16");
    wr(6'h29, 32'h00005555);
    rdCheck(6'h2B, 32'h5555, "R2 incr->baudcnt");
    rdCheck(6'h29, 32'h0000, "R2 incr read 0");
    wr(6'h2C, 32'hFFFF0077);
    rdCheck(6'h2C, 32'h0077, "R2 onems");
    wr(6'h2D, 32'h00000000);
    rdCheck(6'h2D, 32'h0060, "R2 test write ignored");
    rdCheck(6'h3F, 32'h0000, "R2 unmapped");
  endtask

  task automatic t_rx();
    rxPut(8'h41, 1'b0);
    check("R6 rxAccept low", {31'b0, rxAccept}, 32'h0);
    rdCheck(6'h25, 32'h6240, "R5 status1");
    rdCheck(6'h26, 32'h4029, "R5 status2");
    rdCheck(6'h2D, 32'h0040, "R5 test");
    rxPut(8'h42, 1'b0);
    rdCheck(6'h00, 32'h8041, "R6 no overwrite / R4 chrdy");
    rdCheck(6'h25, 32'h6040, "R4 status1 cleared");
    rdCheck(6'h26, 32'h4028, "R4 status2 cleared");
    rdCheck(6'h2D, 32'h0060, "R4 rx empty");
    rdCheck(6'h00, 32'h0041, "R4 second read");
  endtask

  task automatic t_break();
    rxPut(8'h00, 1'b1);
    rdCheck(6'h26, 32'h402D, "R5 break status2");
    rdCheck(6'h00, 32'hD400, "R5 break word");
    rdCheck(6'h26, 32'h402C, "R4 brcd kept");
    wr(6'h26, 32'h0000FFFF);
    rdCheck(6'h26, 32'h4028, "R8 status2 w1c");
    wr(6'h25, 32'h0000FFFF);
    rdCheck(6'h25, 32'h6040, "R8 status1 w1c");
  endtask

  task automatic t_tx();
    wr(6'h10, 32'h5A);
    check("R7 tx disabled", {31'b0, txValid}, 32'h0);
    wr(6'h21, 32'h0005);
    wr(6'h10, 32'h5A);
    check("R7 txValid", {31'b0, txValid}, 32'h1);
    check("R7 txByte", {24'b0, txByte}, 32'h5A);
    rdCheck(6'h25, 32'h4040, "R7 trdy low");
    rdCheck(6'h26, 32'h4020, "R7 txdc low");
    wr(6'h10, 32'hC3);
    check("R7 hold byte", {24'b0, txByte}, 32'h5A);
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    check("R7 consumed", {31'b0, txValid}, 32'h0);
    rdCheck(6'h25, 32'h6040, "R7 trdy back");
    rdCheck(6'h26, 32'h4028, "R7 txdc back");
  endtask

  task automatic t_irq();
    wr(6'h20, 32'h2000);
    check("R11 irq lags", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 trdy irq", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0200);
    settle();
    check("R9 rrdy en, empty", {31'b0, irq}, 32'h0);
    rxPut(8'h11, 1'b0);
    settle();
    check("R9 rrdy irq", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0040);
    settle();
    check("R10 txfe irq", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0000);
    wr(6'h23, 32'h0001);
    settle();
    check("R10 rdr irq", {31'b0, irq}, 32'h1);
    rdCheck(6'h00, 32'h8011, "R4 read");
    settle();
    check("R10 rdr cleared", {31'b0, irq}, 32'h0);
    wr(6'h23, 32'h0008);
    settle();
    check("R10 txdc irq", {31'b0, irq}, 32'h1);
    wr(6'h23, 32'h0000);
    settle();
    check("R10 off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_softreset();
    wr(6'h22, 32'h0001);
    wr(6'h2A, 32'h0033);
    rxPut(8'h77, 1'b0);
    wr(6'h21, 32'h0006);
    rdCheck(6'h21, 32'h0007, "R3 ctrl2 bit0 forced");
    rdCheck(6'h22, 32'h0700, "R3 ctrl3");
    rdCheck(6'h2A, 32'h0000, "R3 modulator");
    rdCheck(6'h2B, 32'h0004, "R3 baudcnt");
    rdCheck(6'h25, 32'h6040, "R3 status1");
    rdCheck(6'h2D, 32'h0060, "R3 test");
    rdCheck(6'h00, 32'h4000, "R3 rxbuf");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_rx();
    t_break();
    t_tx();
    t_irq();
    t_softreset();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule